// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flag-Tagged Queue

This block receives one asynchronous serial line. A 16x oversampling tick paces a bit-level state machine. The machine checks each start bit at its midpoint and assembles characters of 5 to 8 data bits, sent LSB first, with an optional parity or address/data bit. It then tests the first stop bit at its midpoint. Each finished character goes into an eight-deep queue. The character travels with three tags: a break tag, a framing tag and a parity tag.

The processor drains the queue through a valid/ready read stream, and the tags come out alongside the data. When the queue is full, one more character can wait in a holding stage. Back-pressure works as follows: an entry stays on `rd_*` until a cycle with `rd_valid` and `rd_ready` both high removes it. The receiver never stalls the line. Characters that cannot be stored are dropped, and this raises the overrun flag.

Single-cycle command pulses do three things: switch the receiver on, switch it off, and clear the sticky overrun and break-change flags. In wake-up mode the receiver runs even while switched off.

Top module: `async_rx_tagged`

## Requirements
- R1: `char_bits` selects 5+`char_bits` data bits (0 = 5 bits, 3 = 8 bits), received LSB first. The data is presented right-aligned on `rd_data` with the unused upper bits zero. A character is stored whether its flags are clear or not.
- R2: A falling edge starts a character only if the line is still low 8 ticks later. A shorter low pulse produces no entry.
- R3: If the line is low at the middle of the first stop bit, the entry's `rd_fe` is 1.
- R4: `par_mode` selects the ninth bit's meaning:
  - 0: no parity bit; `rd_pe` = 0.
  - 1: parity checked. `par_odd`=1 means odd parity and 0 means even. `rd_pe` = 1 on a mismatch.
  - 2: forced parity. `rd_pe` = 1 when the bit differs from `par_odd`.
  - 3: wake-up. `rd_pe` holds the received address/data bit.
- R5: A character whose data and parity bits are all zero and whose stop bit is low is a break. It is stored as one entry with `rd_brk`=1, `rd_fe`=1 and `rd_data`=0. No further entry is made until the line has been high for 8 consecutive ticks.
- R6: `brk_chg` sets both when a break is detected and when its end (8 high ticks) is detected. It stays set until `cmd_clr_err`. If a set and a clear fall in the same cycle, the set takes precedence.
- R7: The queue holds 8 entries. `rd_valid` is high while it is non-empty, and `st_full` is high while all 8 are occupied.
- R8: A character that completes while the queue is full waits in a holding stage. A read then moves it into the queue in the same cycle, so `st_full` stays high.
- R9: A character that completes while the queue is full and the holding stage is occupied sets `st_ovr`. The waiting character is discarded and the new one takes its place. `st_ovr` stays set until `cmd_clr_err`, and the clear wins over a set in the same cycle.
- R10: `cmd_en` and `cmd_dis` switch the receiver on and off. While it is off, outside wake-up mode, the line is ignored. `cmd_en` outside wake-up mode aborts any character in progress and returns to searching for a start bit.
- R11: After reset, `rd_valid`, `st_full`, `st_ovr` and `brk_chg` are 0 and the receiver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x bit-rate enable |
| rxd | input | 1 | Serial line, idle high |
| cmd_en | input | 1 | Pulse: switch receiver on / restart search |
| cmd_dis | input | 1 | Pulse: switch receiver off |
| cmd_clr_err | input | 1 | Pulse: clear overrun and break-change flags |
| char_bits | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 0 none, 1 checked, 2 forced, 3 wake-up |
| par_odd | input | 1 | Odd parity select / forced bit value |
| rd_valid | output | 1 | Queue head present |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_data | output | 8 | Head character data |
| rd_brk | output | 1 | Head break tag |
| rd_fe | output | 1 | Head framing tag |
| rd_pe | output | 1 | Head parity / address tag |
| st_full | output | 1 | Queue holds 8 entries |
| st_ovr | output | 1 | Sticky overrun |
| brk_chg | output | 1 | Sticky break-change event |

## Verification
The line passes through two synchronizer flops before the state machine sees it. The stop-bit sample registers the finished entry, and the queue write lands on the following edge. So `rd_valid` and the status flags move about four clocks after the middle of the stop bit. The bench holds the line idle for 40 clocks after every frame before it samples anything, which keeps every check clear of that window. Flag clears from `cmd_clr_err` show one clock after the pulse. The bench reads every output at the falling clock edge, and its pops complete on the next rising edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rxq_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
  } rxq_state_t;

  localparam logic [1:0] PM_NONE  = 2'd0;
  localparam logic [1:0] PM_CHECK = 2'd1;
  localparam logic [1:0] PM_FORCE = 2'd2;
  localparam logic [1:0] PM_WAKE  = 2'd3;
endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] char_bits,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  output logic       done,
  output rxq_entry_t entry,
  output logic       brk_evt
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] T_HALF = CW'(HALF - 1);

  rxq_state_t    st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          pbit;
  rxq_entry_t    nxt;
  logic [7:0]    aligned;

  // Right-align the LSB-first shift register and evaluate the flags at the stop sample
  always_comb begin
    aligned  = shreg >> (2'd3 - char_bits);
    nxt.data = aligned;
    nxt.fe   = ~rxd_s;
    unique case (par_mode)
      PM_NONE:  nxt.pe = 1'b0;
      PM_CHECK: nxt.pe = ((^aligned) ^ pbit) != par_odd;
      PM_FORCE: nxt.pe = pbit != par_odd;
      default:  nxt.pe = pbit;
    endcase
    nxt.brk = (aligned == 8'd0) && ((par_mode == PM_NONE) || !pbit) && !rxd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bitn    <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      done    <= 1'b0;
      brk_evt <= 1'b0;
      entry   <= '0;
    end else begin
      done    <= 1'b0;
      brk_evt <= 1'b0;
      if (!run || restart) begin
        st <= S_IDLE;
      end else if (tick) begin
        unique case (st)
          S_IDLE: if (!rxd_s) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (tcnt == T_HALF) begin
            tcnt <= '0;
            bitn <= '0;
            st   <= rxd_s ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 1'b1;
          S_DATA: if (tcnt == T_LAST) begin
            tcnt  <= '0;
            shreg <= {rxd_s, shreg[7:1]};
            if (bitn == {1'b0, char_bits} + 3'd4)
              st <= (par_mode == PM_NONE) ? S_STOP : S_PAR;
            else
              bitn <= bitn + 1'b1;
          end else tcnt <= tcnt + 1'b1;
          S_PAR: if (tcnt == T_LAST) begin
            tcnt <= '0;
            pbit <= rxd_s;
            st   <= S_STOP;
          end else tcnt <= tcnt + 1'b1;
          S_STOP: if (tcnt == T_LAST) begin
            tcnt  <= '0;
            done  <= 1'b1;
            entry <= nxt;
            if (nxt.brk) begin
              st      <= S_BRK;
              brk_evt <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end else tcnt <= tcnt + 1'b1;
          S_BRK: if (rxd_s) begin
            if (tcnt == T_HALF) begin
              st      <= S_IDLE;
              brk_evt <= 1'b1;
              tcnt    <= '0;
            end else tcnt <= tcnt + 1'b1;
          end else tcnt <= '0;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end
endmodule

// File: rtl/async_rx_tagged.sv
module async_rx_tagged
  import rxq_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cmd_en,
  input  logic       cmd_dis,
  input  logic       cmd_clr_err,
  input  logic [1:0] char_bits,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_fe,
  output logic       rd_pe,
  output logic       st_full,
  output logic       st_ovr,
  output logic       brk_chg
);
  localparam int EW = $bits(rxq_entry_t);

  logic [1:0] sync_q;
  logic       rx_on;
  logic       wake, run, restart;
  logic       done, brk_evt;
  rxq_entry_t entry, hold_q, hold_nx, head;
  logic       hold_v, hv_nx;
  logic       f_push, f_full, f_empty, pop, ovr_set;
  rxq_entry_t f_din;
  logic [EW-1:0] f_dout;

  assign wake    = (par_mode == PM_WAKE);
  assign run     = rx_on | wake;
  assign restart = cmd_en & ~wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      rx_on  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      if (cmd_en)       rx_on <= 1'b1;
      else if (cmd_dis) rx_on <= 1'b0;
    end
  end

  rxq_sampler #(.OVS(OVS)) u_samp (
    .clk, .rst_n, .tick(tick16), .rxd_s(sync_q[1]), .run, .restart,
    .char_bits, .par_mode, .par_odd, .done, .entry, .brk_evt
  );

  assign pop = rd_valid & rd_ready;

  // Queue feed: holding stage drains on a read; a third pending character overruns
  always_comb begin
    f_push  = 1'b0;
    f_din   = hold_q;
    hold_nx = hold_q;
    hv_nx   = hold_v;
    ovr_set = 1'b0;
    if (pop && hold_v) begin
      f_push = 1'b1;
      if (done) hold_nx = entry;
      else      hv_nx   = 1'b0;
    end else if (done) begin
      if (!f_full || pop) begin
        f_push = 1'b1;
        f_din  = entry;
      end else if (!hold_v) begin
        hv_nx   = 1'b1;
        hold_nx = entry;
      end else begin
        hold_nx = entry;
        ovr_set = 1'b1;
      end
    end
  end

  rxq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .push(f_push), .din(f_din), .pop,
    .dout(f_dout), .full(f_full), .empty(f_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hold_v  <= 1'b0;
      st_ovr  <= 1'b0;
      brk_chg <= 1'b0;
    end else begin
      hold_q <= hold_nx;
      hold_v <= hv_nx;
      if (cmd_clr_err)  st_ovr <= 1'b0;
      else if (ovr_set) st_ovr <= 1'b1;
      if (brk_evt)          brk_chg <= 1'b1;
      else if (cmd_clr_err) brk_chg <= 1'b0;
    end
  end

  assign head     = rxq_entry_t'(f_dout);
  assign rd_valid = ~f_empty;
  assign rd_data  = head.data;
  assign rd_brk   = head.brk;
  assign rd_fe    = head.fe;
  assign rd_pe    = head.pe;
  assign st_full  = f_full;
endmodule

// File: rtl/async_rx_tagged_chk.sv
module async_rx_tagged_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_brk,
  input logic       rd_fe,
  input logic       st_full,
  input logic       st_ovr,
  input logic       cmd_clr_err
);
  p_full_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> rd_valid);

  p_brk_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_brk) |-> (rd_data == 8'd0 && rd_fe));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !cmd_clr_err) |=> st_ovr);

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_err |=> !st_ovr);

  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(st_full));
endmodule

bind async_rx_tagged async_rx_tagged_chk u_chk (.*);

// File: tb/async_rx_tagged_tb.sv
module async_rx_tagged_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b1;
  logic rxd = 1'b1;
  logic cmd_en = 1'b0, cmd_dis = 1'b0, cmd_clr_err = 1'b0;
  logic [1:0] char_bits = 2'd3, par_mode = 2'd0;
  logic par_odd = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic rd_brk, rd_fe, rd_pe, st_full, st_ovr, brk_chg;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  async_rx_tagged u_dut (.*);

  // {char_bits, par_mode, par_odd, data, parity bit, stop bit}
  localparam logic [14:0] VEC [9] = '{
    {2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1},
    {2'd0, 2'd0, 1'b0, 8'hFF, 1'b0, 1'b1},
    {2'd2, 2'd1, 1'b0, 8'h55, 1'b0, 1'b1},
    {2'd3, 2'd1, 1'b0, 8'h01, 1'b0, 1'b1},
    {2'd3, 2'd1, 1'b1, 8'h03, 1'b1, 1'b1},
    {2'd3, 2'd2, 1'b1, 8'h10, 1'b0, 1'b1},
    {2'd3, 2'd3, 1'b0, 8'h42, 1'b1, 1'b1},
    {2'd3, 2'd0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic v, int n = 16);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [1:0] cb, logic [1:0] pm, logic [7:0] d,
                            logic pb, logic stp);
    send_bit(1'b0);
    for (int i = 0; i < 5 + cb; i++) send_bit(d[i]);
    if (pm != 2'd0) send_bit(pb);
    send_bit(stp);
    send_bit(1'b1, 40);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic pop_chk(string tag, logic [7:0] d, logic b, logic f, logic p);
    chk({tag, " valid"}, rd_valid, 1);
    chk({tag, " data"}, rd_data, d);
    chk({tag, " brk/fe/pe"}, {rd_brk, rd_fe, rd_pe}, {b, f, p});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset flags", {rd_valid, st_full, st_ovr, brk_chg}, 4'b0000);
    pulse(cmd_en);

    // Table walk: R1 widths, R3 framing, R4 parity modes, R5 break
    foreach (VEC[k]) begin
      logic [1:0] cb, pm;
      logic po, pb, sp, ebrk, efe, epe;
      logic [7:0] d, ed;
      {cb, pm, po, d, pb, sp} = VEC[k];
      char_bits = cb; par_mode = pm; par_odd = po;
      @(negedge clk);
      send_frame(cb, pm, d, pb, sp);
      ed   = d & ((8'd1 << (5 + cb)) - 8'd1);
      efe  = ~sp;
      ebrk = (ed == 8'd0) && (pm == 2'd0 || !pb) && !sp;
      case (pm)
        2'd0: epe = 1'b0;
        2'd1: epe = ((^ed) ^ pb) != po;
        2'd2: epe = pb != po;
        default: epe = pb;
      endcase
      pop_chk($sformatf("R1/R3/R4/R5 vec%0d", k), ed, ebrk, efe, epe);
      chk($sformatf("R7 vec%0d drained", k), rd_valid, 0);
    end
    chk("R6 break change after table break", brk_chg, 1);
    pulse(cmd_clr_err);
    chk("R6 cleared", brk_chg, 0);
    char_bits = 2'd3; par_mode = 2'd0; par_odd = 1'b0;

    // R2: short low glitch
    send_bit(1'b0, 4);
    send_bit(1'b1, 300);
    chk("R2 glitch ignored", rd_valid, 0);

    // R10: abort mid-frame by re-enable
    send_bit(1'b0, 16);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    pulse(cmd_en);
    send_bit(1'b1, 250);
    chk("R10 restart aborts frame", rd_valid, 0);

    // R10: disabled ignores line; wake-up mode still receives
    pulse(cmd_dis);
    send_frame(2'd3, 2'd0, 8'h5A, 1'b0, 1'b1);
    chk("R10 disabled ignores line", rd_valid, 0);
    par_mode = 2'd3;
    send_frame(2'd3, 2'd3, 8'h42, 1'b0, 1'b1);
    pop_chk("R10/R4 wake while disabled", 8'h42, 1'b0, 1'b0, 1'b0);
    par_mode = 2'd0;
    pulse(cmd_en);

    // R7/R8/R9: fill, hold, overrun
    for (int i = 0; i < 8; i++) send_frame(2'd3, 2'd0, 8'(i), 1'b0, 1'b1);
    chk("R7 full after eight", st_full, 1);
    send_frame(2'd3, 2'd0, 8'd8, 1'b0, 1'b1);
    chk("R8 held char no overrun", st_ovr, 0);
    pop_chk("R7 first out", 8'd0, 1'b0, 1'b0, 1'b0);
    chk("R8 full stays after read with held char", st_full, 1);
    send_frame(2'd3, 2'd0, 8'd9, 1'b0, 1'b1);
    chk("R9 no overrun while hold free", st_ovr, 0);
    send_frame(2'd3, 2'd0, 8'd10, 1'b0, 1'b1);
    chk("R9 overrun set", st_ovr, 1);
    pop_chk("R8 order 1", 8'd1, 1'b0, 1'b0, 1'b0);
    chk("R8 still full", st_full, 1);
    pop_chk("R8 order 2", 8'd2, 1'b0, 1'b0, 1'b0);
    chk("R7 not full at seven", st_full, 0);
    for (int i = 3; i <= 8; i++) pop_chk($sformatf("R8 order %0d", i), 8'(i), 1'b0, 1'b0, 1'b0);
    pop_chk("R9 replacement kept", 8'd10, 1'b0, 1'b0, 1'b0);
    chk("R9 discarded char absent", rd_valid, 0);
    chk("R9 overrun sticky", st_ovr, 1);
    pulse(cmd_clr_err);
    chk("R9 overrun cleared", st_ovr, 0);

    // R5/R6: long break, single entry, both edges flagged
    send_bit(1'b0, 160 + 40);
    chk("R6 set on break detect", brk_chg, 1);
    pulse(cmd_clr_err);
    chk("R6 cleared during break", brk_chg, 0);
    send_bit(1'b0, 480);
    chk("R6 no event while still low", brk_chg, 0);
    send_bit(1'b1, 30);
    chk("R6 set on break end", brk_chg, 1);
    pop_chk("R5 single break entry", 8'd0, 1'b1, 1'b1, 1'b0);
    chk("R5 no second entry", rd_valid, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule